// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Multiple Parent Outputs

This block gathers a word of level-sensitive interrupt lines, one bit per source, and drives a small set of parent interrupt outputs from them. Each source line passes through a two-stage synchroniser into a raw status register. The status register always mirrors the synchronised lines. Nothing latches an edge, and no acknowledge or write-to-clear action exists. A read/write enable register gates which sources may raise an interrupt. Each parent output has its own routing mask that picks the sources it serves.

Software uses a simple register port to reach the enable word, the status word and the per-parent routing masks. Masking a source means clearing its enable bit, and unmasking it means setting the bit. At reset the enable word loads a build-time forward mask, so chosen sources start out enabled.

During suspend, when wake capability is built in, the enable used for routing becomes the saved enable ORed with a wake mask. The wake mask is restricted to sources that at least one routing mask covers. When suspend ends, the saved enable alone applies again.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset the enable register reads the forward-mask parameter value, every routing mask reads all ones, and all parent outputs are low.
- R2: Status bit i reads the level of source i as sampled two clock edges earlier. Writes to the status offset 0x04 change no register.
- R3: The enable register at offset 0x00 is plain read/write. A write stores the full data word.
- R4: The routing mask of parent n is read/write at offset 0x08 + 4*n. A read of an offset that decodes to no register returns zero.
- R5: Parent output n is high exactly when (status AND effective enable AND routing mask n) is non-zero. It is registered one edge after the status register, which is three edges after a source change.
- R6: When suspend is high and wake capability is built in, the effective enable is enable OR (wake mask AND covered sources). When suspend is low, it is the enable alone.
- R7: A source that no routing mask covers never raises any parent output, even when it is enabled or wake-enabled.
- R8: Read data appears on the read-data port after the clock edge that samples the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive source lines |
| wake_mask_i | input | NSRC | Sources allowed to wake during suspend |
| suspend_i | input | 1 | Suspend state |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte offset of the register |
| bus_wdata_i | input | NSRC | Write data |
| bus_rdata_o | output | NSRC | Registered read data |
| irq_o | output | NPARENT | Registered parent interrupt outputs |

## Verification
A wrong enable or routing bit shows up on a parent output three edges after the affected source rises, and it shows at once on a readback of that register. A synchroniser of the wrong depth moves the status readback and the output transition by one edge. The latency checks sample on both sides of the expected edge to catch this. A wrong suspend path appears one edge after suspend toggles, as a parent output that should follow the wake mask but stays low, or as one that stays high after resume.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned OFS_ENABLE  = 0;
  localparam int unsigned OFS_STATUS  = 4;
  localparam int unsigned OFS_MAP0    = 8;
  localparam int unsigned MAP_STRIDE  = 4;
  localparam int unsigned MAX_PARENTS = 4;

  function automatic int unsigned map_offset(input int unsigned n);
    return OFS_MAP0 + MAP_STRIDE * n;
  endfunction
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stat_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stat_q <= '0;
      age_q  <= '0;
    end else begin
      meta_q <= d_i;
      stat_q <= meta_q;
      if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
  end

  assign q_o = stat_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R2
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned NP       = 2,
  parameter int unsigned AW       = 8,
  parameter logic [W-1:0] FWD_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_i,
  input  logic                 wr_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [W-1:0]         wdata_i,
  input  logic [W-1:0]         status_i,
  output logic [W-1:0]         rdata_o,
  output logic [W-1:0]         en_o,
  output logic [NP-1:0][W-1:0] map_o
);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_ENABLE);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STATUS);

  logic [W-1:0]         en_q, rd_mux, rdata_q;
  logic [NP-1:0][W-1:0] map_q;
  logic [NP-1:0]        map_hit;

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_EN)   rd_mux = en_q;
    if (addr_i == A_STAT) rd_mux = status_i;
    for (int n = 0; n < NP; n++) begin
      map_hit[n] = (addr_i == AW'(map_offset(n)));
      if (map_hit[n]) rd_mux = map_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= FWD_INIT;
      rdata_q <= '0;
      for (int n = 0; n < NP; n++) map_q[n] <= '1;
    end else if (sel_i) begin
      if (wr_i) begin
        if (addr_i == A_EN) en_q <= wdata_i;
        for (int n = 0; n < NP; n++)
          if (map_hit[n]) map_q[n] <= wdata_i;
      end else begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign en_o    = en_q;
  assign map_o   = map_q;
  assign rdata_o = rdata_q;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (sel_i && wr_i && addr_i == A_EN) |=> (en_o == $past(wdata_i))); // R3
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
    (sel_i && wr_i && addr_i == A_STAT) |=> ($stable(en_o) && $stable(map_o))); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && !wr_i) |=> $stable(rdata_o)); // R8
endmodule

// File: rtl/lvl_irq_route.sv
module lvl_irq_route #(
  parameter int unsigned W        = 32,
  parameter int unsigned NP       = 2,
  parameter bit          WAKE_CAP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         status_i,
  input  logic [W-1:0]         en_i,
  input  logic [NP-1:0][W-1:0] map_i,
  input  logic [W-1:0]         wake_i,
  input  logic                 suspend_i,
  output logic [NP-1:0]        irq_o
);
  logic [W-1:0]  covered, eff_en;
  logic [NP-1:0] irq_q;

  always_comb begin
    covered = '0;
    for (int n = 0; n < NP; n++) covered = covered | map_i[n];
    eff_en = (WAKE_CAP && suspend_i) ? (en_i | (wake_i & covered)) : en_i;
  end

  for (genvar n = 0; n < NP; n++) begin : g_parent
    always_ff @(posedge clk) begin
      if (rst) irq_q[n] <= 1'b0;
      else     irq_q[n] <= |(status_i & eff_en & map_i[n]);
    end

    AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (rst)
      irq_q[n] |-> $past(|(status_i & map_i[n]))); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
      ($past(status_i) == '0) |-> !irq_q[n]); // R5
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_pkg::*;
#(
  parameter int unsigned  NSRC     = 32,
  parameter int unsigned  NPARENT  = 2,
  parameter int unsigned  AW       = 8,
  parameter logic [NSRC-1:0] FWD_INIT = '0,
  parameter bit           WAKE_CAP = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NSRC-1:0]    src_i,
  input  logic [NSRC-1:0]    wake_mask_i,
  input  logic               suspend_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [NSRC-1:0]    bus_wdata_i,
  output logic [NSRC-1:0]    bus_rdata_o,
  output logic [NPARENT-1:0] irq_o
);
  logic [NSRC-1:0]              status;
  logic [NSRC-1:0]              enable;
  logic [NPARENT-1:0][NSRC-1:0] route;

  initial begin
    assert (NPARENT >= 1 && NPARENT <= MAX_PARENTS && NSRC <= 32)
      else $error("lvl_irq_router: unsupported configuration");
  end

  lvl_irq_sync #(.W(NSRC)) u_sync (
    .clk (clk), .rst (rst), .d_i (src_i), .q_o (status)
  );

  lvl_irq_regs #(.W(NSRC), .NP(NPARENT), .AW(AW), .FWD_INIT(FWD_INIT)) u_regs (
    .clk (clk), .rst (rst),
    .sel_i (bus_sel_i), .wr_i (bus_wr_i), .addr_i (bus_addr_i),
    .wdata_i (bus_wdata_i), .status_i (status),
    .rdata_o (bus_rdata_o), .en_o (enable), .map_o (route)
  );

  lvl_irq_route #(.W(NSRC), .NP(NPARENT), .WAKE_CAP(WAKE_CAP)) u_route (
    .clk (clk), .rst (rst),
    .status_i (status), .en_i (enable), .map_i (route),
    .wake_i (wake_mask_i), .suspend_i (suspend_i), .irq_o (irq_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0)); // R1
endmodule

// File: tb/sim_lvl_irq_router.sv
`timescale 1ns/1ps
module sim_lvl_irq_router;
  localparam int unsigned NS = 32;
  localparam int unsigned NP = 2;
  localparam logic [NS-1:0] FWD = 32'h0000_00F0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src = '0, wake = '0, wdata = '0;
  logic          susp = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [7:0]    addr = '0;
  logic [NS-1:0] rdata;
  logic [NP-1:0] irq;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  lvl_irq_router #(.NSRC(NS), .NPARENT(NP), .AW(8), .FWD_INIT(FWD), .WAKE_CAP(1'b1)) u0 (
    .clk (clk), .rst (rst), .src_i (src), .wake_mask_i (wake), .suspend_i (susp),
    .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr), .bus_wdata_i (wdata),
    .bus_rdata_o (rdata), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [NS-1:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [NS-1:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  function automatic logic [NP-1:0] exp_irq(input logic [NS-1:0] s, input logic [NS-1:0] e,
                                             input logic [NS-1:0] m0, input logic [NS-1:0] m1);
    return {|(s & e & m1), |(s & e & m0)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [NS-1:0] v;
    logic [NS-1:0] m0, m1, en;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    chk("R1 irq", 32'(irq), 32'h0);
    rd_reg(8'h00, v); chk("R1 enable", v, FWD);
    rd_reg(8'h08, v); chk("R1 map0", v, '1);
    rd_reg(8'h0C, v); chk("R1 map1", v, '1);

    // R4 map programming and unmapped offsets
    m0 = 32'h0000_FFFF; m1 = 32'h00FF_0000;
    wr_reg(8'h08, m0); wr_reg(8'h0C, m1);
    rd_reg(8'h08, v); chk("R4 map0", v, m0);
    rd_reg(8'h0C, v); chk("R4 map1", v, m1);
    rd_reg(8'h10, v); chk("R4 unmapped", v, '0);
    rd_reg(8'h40, v); chk("R4 unmapped", v, '0);

    // R3 enable read/write
    wr_reg(8'h00, 32'hA5C3_0F96);
    rd_reg(8'h00, v); chk("R3 enable", v, 32'hA5C3_0F96);

    // R5 R7 sweep over every source, two enable patterns
    for (int pass = 0; pass < 2; pass++) begin
      en = (pass == 0) ? '1 : 32'h5555_5555;
      wr_reg(8'h00, en);
      for (int i = 0; i < NS; i++) begin
        src = NS'(1) << i;
        repeat (3) @(negedge clk);
        chk("R5 R7 route", 32'(irq), 32'(exp_irq(src, en, m0, m1)));
        rd_reg(8'h04, v); chk("R2 status", v, src);
        src = '0;
        repeat (3) @(negedge clk);
      end
    end

    // R5 latency: source change shows after three edges, not two
    wr_reg(8'h00, '1);
    src = 32'h0000_0001;
    repeat (2) @(negedge clk);
    chk("R5 early", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R5 on time", 32'(irq), 32'h1);
    // R2 status is not clearable by write
    wr_reg(8'h04, '1);
    rd_reg(8'h04, v); chk("R2 no clear", v, 32'h0000_0001);
    rd_reg(8'h00, v); chk("R2 enable untouched", v, '1);
    rd_reg(8'h08, v); chk("R2 map untouched", v, m0);
    // R2 level follows input when it drops
    src = '0;
    repeat (3) @(negedge clk);
    rd_reg(8'h04, v); chk("R2 follows level", v, '0);
    chk("R5 drop", 32'(irq), 32'h0);

    // R8 read data holds without a strobe
    rd_reg(8'h08, v);
    wr_reg(8'h00, 32'h1234_5678);
    repeat (2) @(negedge clk);
    chk("R8 hold", rdata, m0);

    // R6 suspend wake path
    wr_reg(8'h00, '0);
    wake = '1;
    src = 32'h1001_0008;   // bit 3 (map0), bit 16 (map1), bit 28 unused
    repeat (3) @(negedge clk);
    chk("R6 awake masked", 32'(irq), 32'h0);
    susp = 1'b1;
    @(negedge clk);
    chk("R6 suspended wake", 32'(irq), 32'h3);
    wake = 32'h0001_0000;
    @(negedge clk);
    chk("R6 wake subset", 32'(irq), 32'h2);
    // R7 unused source with wake and enable stays silent
    src = 32'h1000_0000; wake = '1;
    wr_reg(8'h00, 32'h1000_0000);
    repeat (3) @(negedge clk);
    chk("R7 unused silent", 32'(irq), 32'h0);
    // R6 resume returns to enable alone
    src = 32'h0000_0008;
    wr_reg(8'h00, '0);
    repeat (3) @(negedge clk);
    chk("R6 still suspended", 32'(irq), 32'h1);
    susp = 1'b0;
    @(negedge clk);
    chk("R6 resume", 32'(irq), 32'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule